// File: doc/BRIEF.md
# I2C Slave Address and General-Call Decoder

This block sits behind an I2C receive front end that has already turned the wire activity into whole bytes and bus events. For every transaction it looks at the address-phase bytes and decides whether this device is being selected and whether each of those bytes gets an acknowledge. The device address is programmable. It can be used as a 7-bit address or as a 10-bit address sent in two bytes.

Alongside the normal address compare, the block recognises three special cases. The first is the broadcast address, in which case the following command byte is interpreted. The second is the byte that marks a long transfer by another master. The third is the two-byte 10-bit address form. From a broadcast it raises one-cycle requests for a device reset and for an address report. It can also capture the identity of a master that announces itself.

The front end reports a start (including a repeated start), a stop, and each received byte together with its index in the transaction. The front end uses the acknowledge decision to drive the ninth clock. The host logic uses the request pulses.

Top module: `i2c_addr_decoder`

## Requirements
- R1: After synchronous reset all outputs are 0.
- R2: A decision appears on the outputs in the cycle after `rx_valid`. `ack_valid` pulses for one cycle and `ack` is only ever high together with it. In 7-bit mode (`cfg_ten_bit`=0), a first byte (index 0) whose bits [7:1] equal `cfg_own_addr[6:0]` is acknowledged. It also sets `addr_match`, and `read_dir` takes bit 0 of that byte. Every other ordinary first byte is answered with `ack`=0. `cfg_own_addr[9:7]` has no effect in this mode.
- R3: A first byte of 0x00 is a broadcast. It is acknowledged when `cfg_gc_enable`=1. When `cfg_gc_enable`=0 it gets `ack`=0, and the byte at index 1 produces no decision and no request.
- R4: After an acknowledged broadcast, a byte 0x06 at index 1 is acknowledged and pulses both `gc_reset_req` and `gc_report_req`.
- R5: After an acknowledged broadcast, a byte 0x04 at index 1 is acknowledged and pulses `gc_report_req` only.
- R6: After an acknowledged broadcast, any other byte at index 1 with bit 0 = 0 gets `ack`=0 and raises no request.
- R7: After an acknowledged broadcast, a byte at index 1 with bit 0 = 1 is acknowledged. It pulses `master_id_valid`, and `master_id` holds bits [7:1] of that byte.
- R8: A first byte of 0x01 pulses `start_byte_seen` and is answered with `ack`=0, in both modes.
- R9: In 7-bit mode, a first byte with bits [7:3] = 11110 gets `ack`=0 and never selects the device.
- R10: In 10-bit mode, a first byte 11110xyd is acknowledged only when xy equals `cfg_own_addr[9:8]`, and `read_dir` takes d. The byte at index 1 is then decided, and it is acknowledged, setting `addr_match`, only if it equals `cfg_own_addr[7:0]`. After a mismatched prefix the index-1 byte produces no decision. Ordinary 7-bit address bytes are answered with `ack`=0 in this mode.
- R11: `bus_start` or `bus_stop` clears `addr_match`, `read_dir` and all partial decode state by the next cycle. A byte presented in the same cycle as either of them is discarded.
- R12: Bytes at index 2 or above produce no decision and leave `addr_match` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_own_addr | input | 10 | Own address; bits [6:0] used in 7-bit mode |
| cfg_ten_bit | input | 1 | 1 selects 10-bit addressing |
| cfg_gc_enable | input | 1 | 1 enables the response to broadcasts |
| bus_start | input | 1 | Start or repeated start seen (pulse) |
| bus_stop | input | 1 | Stop seen (pulse) |
| rx_valid | input | 1 | A received byte is presented |
| rx_index | input | IDX_W | Position of the byte in the transaction, 0 first |
| rx_byte | input | 8 | Received byte |
| ack_valid | output | 1 | Acknowledge decision available (pulse) |
| ack | output | 1 | Acknowledge the byte |
| addr_match | output | 1 | Device is selected in this transaction |
| read_dir | output | 1 | Direction bit of the selecting address |
| gc_reset_req | output | 1 | Broadcast reset request (pulse) |
| gc_report_req | output | 1 | Broadcast address-report request (pulse) |
| master_id_valid | output | 1 | Master announcement captured (pulse) |
| master_id | output | 7 | Address of the announcing master |
| start_byte_seen | output | 1 | Long-transfer marker byte seen (pulse) |

## Verification
All 256 first-byte values are applied under four configurations: 7-bit mode with broadcast response on and off, and 10-bit mode with two addresses whose high bits differ. This separates the ordinary compare, the broadcast, the marker byte and the 10-bit prefix. It also shows that each takes precedence as intended. All 256 command bytes are swept after a broadcast, which tells reset, report, ignored and announcement commands apart. All 256 low-address bytes are swept after a matching prefix, which checks that only the exact 10-bit address selects the device. Directed sequences cover a stop between the two address bytes, a start coinciding with a byte, and bytes beyond index 1.

// File: rtl/i2c_dec_pkg.sv
package i2c_dec_pkg;

    localparam int BYTE_W  = 8;
    localparam int OWN_W   = 10;
    localparam int ADDR7_W = 7;
    localparam int HI_W    = OWN_W - BYTE_W;

    localparam logic [BYTE_W-1:0] GC_FIRST      = 8'h00;
    localparam logic [BYTE_W-1:0] MARKER_BYTE   = 8'h01;
    localparam logic [BYTE_W-1:0] GC_RESET_CMD  = 8'h06;
    localparam logic [BYTE_W-1:0] GC_REPORT_CMD = 8'h04;
    localparam logic [4:0]        TEN_MARK      = 5'b11110;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_GC_CMD,
        PH_TEN_LOW,
        PH_SELECTED,
        PH_IGNORE
    } phase_t;

    typedef struct packed {
        logic               ack;
        logic               sel;
        logic               rw;
        logic               gc_rst;
        logic               gc_rep;
        logic               mst_v;
        logic [ADDR7_W-1:0] mst;
        logic               sbyte;
        phase_t             nxt;
    } verdict_t;

    function automatic verdict_t verdict_none();
        verdict_t v;
        v.ack    = 1'b0;
        v.sel    = 1'b0;
        v.rw     = 1'b0;
        v.gc_rst = 1'b0;
        v.gc_rep = 1'b0;
        v.mst_v  = 1'b0;
        v.mst    = '0;
        v.sbyte  = 1'b0;
        v.nxt    = PH_IGNORE;
        return v;
    endfunction

    function automatic logic is_ten_prefix(input logic [BYTE_W-1:0] b);
        return b[7:3] == TEN_MARK;
    endfunction

endpackage

// File: rtl/i2c_first_byte_dec.sv
module i2c_first_byte_dec
    import i2c_dec_pkg::*;
(
    input  logic [BYTE_W-1:0]  rx_byte,
    input  logic [ADDR7_W-1:0] own7,
    input  logic [HI_W-1:0]    own_hi,
    input  logic               ten_bit,
    input  logic               gc_en,
    output verdict_t           verdict
);

    always_comb begin
        verdict = verdict_none();
        if (rx_byte == GC_FIRST) begin
            verdict.ack = gc_en;
            verdict.nxt = gc_en ? PH_GC_CMD : PH_IGNORE;
        end else if (rx_byte == MARKER_BYTE) begin
            verdict.sbyte = 1'b1;
        end else if (is_ten_prefix(rx_byte)) begin
            if (ten_bit && (rx_byte[2:1] == own_hi)) begin
                verdict.ack = 1'b1;
                verdict.rw  = rx_byte[0];
                verdict.nxt = PH_TEN_LOW;
            end
        end else if (!ten_bit && (rx_byte[7:1] == own7)) begin
            verdict.ack = 1'b1;
            verdict.sel = 1'b1;
            verdict.rw  = rx_byte[0];
            verdict.nxt = PH_SELECTED;
        end
    end

endmodule

// File: rtl/i2c_second_byte_dec.sv
module i2c_second_byte_dec
    import i2c_dec_pkg::*;
(
    input  phase_t            phase,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic [BYTE_W-1:0] own_lo,
    output logic              decides,
    output verdict_t          verdict
);

    always_comb begin
        verdict = verdict_none();
        decides = 1'b0;
        unique case (phase)
            PH_GC_CMD: begin
                decides = 1'b1;
                if (rx_byte == GC_RESET_CMD) begin
                    verdict.ack    = 1'b1;
                    verdict.gc_rst = 1'b1;
                    verdict.gc_rep = 1'b1;
                end else if (rx_byte == GC_REPORT_CMD) begin
                    verdict.ack    = 1'b1;
                    verdict.gc_rep = 1'b1;
                end else if (rx_byte[0]) begin
                    verdict.ack   = 1'b1;
                    verdict.mst_v = 1'b1;
                    verdict.mst   = rx_byte[7:1];
                end
            end
            PH_TEN_LOW: begin
                decides = 1'b1;
                if (rx_byte == own_lo) begin
                    verdict.ack = 1'b1;
                    verdict.sel = 1'b1;
                    verdict.nxt = PH_SELECTED;
                end
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/i2c_addr_decoder.sv
module i2c_addr_decoder
    import i2c_dec_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [OWN_W-1:0]    cfg_own_addr,
    input  logic                cfg_ten_bit,
    input  logic                cfg_gc_enable,
    input  logic                bus_start,
    input  logic                bus_stop,
    input  logic                rx_valid,
    input  logic [IDX_W-1:0]    rx_index,
    input  logic [BYTE_W-1:0]   rx_byte,
    output logic                ack_valid,
    output logic                ack,
    output logic                addr_match,
    output logic                read_dir,
    output logic                gc_reset_req,
    output logic                gc_report_req,
    output logic                master_id_valid,
    output logic [ADDR7_W-1:0]  master_id,
    output logic                start_byte_seen
);

    localparam logic [IDX_W-1:0] IDX_FIRST  = '0;
    localparam logic [IDX_W-1:0] IDX_SECOND = IDX_W'(1);

    phase_t   phase_q;
    verdict_t v_first;
    verdict_t v_second;
    logic     second_decides;

    i2c_first_byte_dec u_first (
        .rx_byte (rx_byte),
        .own7    (cfg_own_addr[ADDR7_W-1:0]),
        .own_hi  (cfg_own_addr[OWN_W-1:BYTE_W]),
        .ten_bit (cfg_ten_bit),
        .gc_en   (cfg_gc_enable),
        .verdict (v_first)
    );

    i2c_second_byte_dec u_second (
        .phase   (phase_q),
        .rx_byte (rx_byte),
        .own_lo  (cfg_own_addr[BYTE_W-1:0]),
        .decides (second_decides),
        .verdict (v_second)
    );

    wire take_first  = rx_valid && (rx_index == IDX_FIRST);
    wire take_second = rx_valid && (rx_index == IDX_SECOND) && second_decides;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q         <= PH_IDLE;
            ack_valid       <= 1'b0;
            ack             <= 1'b0;
            addr_match      <= 1'b0;
            read_dir        <= 1'b0;
            gc_reset_req    <= 1'b0;
            gc_report_req   <= 1'b0;
            master_id_valid <= 1'b0;
            master_id       <= '0;
            start_byte_seen <= 1'b0;
        end else begin
            ack_valid       <= 1'b0;
            ack             <= 1'b0;
            gc_reset_req    <= 1'b0;
            gc_report_req   <= 1'b0;
            master_id_valid <= 1'b0;
            start_byte_seen <= 1'b0;
            if (bus_start || bus_stop) begin
                phase_q    <= PH_IDLE;
                addr_match <= 1'b0;
                read_dir   <= 1'b0;
            end else if (take_first) begin
                phase_q         <= v_first.nxt;
                ack_valid       <= 1'b1;
                ack             <= v_first.ack;
                addr_match      <= v_first.sel;
                read_dir        <= v_first.rw;
                start_byte_seen <= v_first.sbyte;
            end else if (take_second) begin
                phase_q         <= v_second.nxt;
                ack_valid       <= 1'b1;
                ack             <= v_second.ack;
                addr_match      <= v_second.sel;
                gc_reset_req    <= v_second.gc_rst;
                gc_report_req   <= v_second.gc_rep;
                master_id_valid <= v_second.mst_v;
                if (v_second.mst_v) begin
                    master_id <= v_second.mst;
                end
            end
        end
    end

endmodule

module i2c_addr_decoder_chk
    import i2c_dec_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input logic               clk,
    input logic               rst,
    input logic               cfg_ten_bit,
    input logic               cfg_gc_enable,
    input logic               bus_start,
    input logic               bus_stop,
    input logic               rx_valid,
    input logic [IDX_W-1:0]   rx_index,
    input logic [BYTE_W-1:0]  rx_byte,
    input logic               ack_valid,
    input logic               ack,
    input logic               addr_match,
    input logic               gc_reset_req,
    input logic               gc_report_req,
    input logic               master_id_valid,
    input logic               start_byte_seen
);

    wire fresh = rx_valid && !bus_start && !bus_stop;

    // R2
    ack_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
        ack |-> ack_valid);

    // R3
    gc_disabled_nack_chk: assert property (@(posedge clk) disable iff (rst)
        fresh && rx_index == '0 && rx_byte == GC_FIRST && !cfg_gc_enable
        |=> ack_valid && !ack);

    // R4
    reset_brings_report_chk: assert property (@(posedge clk) disable iff (rst)
        gc_reset_req |-> gc_report_req && ack && ack_valid);

    // R7
    master_capture_acked_chk: assert property (@(posedge clk) disable iff (rst)
        master_id_valid |-> ack && ack_valid && !gc_report_req);

    // R8
    marker_never_acked_chk: assert property (@(posedge clk) disable iff (rst)
        fresh && rx_index == '0 && rx_byte == MARKER_BYTE
        |=> ack_valid && !ack && start_byte_seen && !addr_match);

    // R9
    prefix_in_seven_bit_chk: assert property (@(posedge clk) disable iff (rst)
        fresh && rx_index == '0 && rx_byte[7:3] == TEN_MARK && !cfg_ten_bit
        |=> !ack && !addr_match);

    // R11
    bus_event_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_start || bus_stop) |=> !addr_match && !ack_valid);

    // R12
    late_byte_silent_chk: assert property (@(posedge clk) disable iff (rst)
        fresh && rx_index > IDX_W'(1) |=> !ack_valid && $stable(addr_match));

endmodule

bind i2c_addr_decoder i2c_addr_decoder_chk #(.IDX_W(IDX_W)) u_chk (
    .clk             (clk),
    .rst             (rst),
    .cfg_ten_bit     (cfg_ten_bit),
    .cfg_gc_enable   (cfg_gc_enable),
    .bus_start       (bus_start),
    .bus_stop        (bus_stop),
    .rx_valid        (rx_valid),
    .rx_index        (rx_index),
    .rx_byte         (rx_byte),
    .ack_valid       (ack_valid),
    .ack             (ack),
    .addr_match      (addr_match),
    .gc_reset_req    (gc_reset_req),
    .gc_report_req   (gc_report_req),
    .master_id_valid (master_id_valid),
    .start_byte_seen (start_byte_seen)
);

// File: tb/i2c_addr_decoder_tb.sv
`timescale 1ns/1ps
module i2c_addr_decoder_tb;

    localparam int IDX_W = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [9:0]  cfg_own_addr = '0;
    logic        cfg_ten_bit = 1'b0;
    logic        cfg_gc_enable = 1'b1;
    logic        bus_start = 1'b0;
    logic        bus_stop = 1'b0;
    logic        rx_valid = 1'b0;
    logic [IDX_W-1:0] rx_index = '0;
    logic [7:0]  rx_byte = '0;
    logic        ack_valid, ack, addr_match, read_dir;
    logic        gc_reset_req, gc_report_req, master_id_valid, start_byte_seen;
    logic [6:0]  master_id;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    i2c_addr_decoder #(.IDX_W(IDX_W)) u_dut (
        .clk(clk), .rst(rst), .cfg_own_addr(cfg_own_addr),
        .cfg_ten_bit(cfg_ten_bit), .cfg_gc_enable(cfg_gc_enable),
        .bus_start(bus_start), .bus_stop(bus_stop),
        .rx_valid(rx_valid), .rx_index(rx_index), .rx_byte(rx_byte),
        .ack_valid(ack_valid), .ack(ack), .addr_match(addr_match),
        .read_dir(read_dir), .gc_reset_req(gc_reset_req),
        .gc_report_req(gc_report_req), .master_id_valid(master_id_valid),
        .master_id(master_id), .start_byte_seen(start_byte_seen)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    endtask

    task automatic pulse_start();
        @(negedge clk); bus_start = 1'b1;
        @(negedge clk); bus_start = 1'b0;
    endtask

    task automatic pulse_stop();
        @(negedge clk); bus_stop = 1'b1;
        @(negedge clk); bus_stop = 1'b0;
    endtask

    // Drive one byte; returns at the negedge where the registered decision is visible.
    task automatic send_byte(input int idx, input logic [7:0] b);
        @(negedge clk);
        rx_valid = 1'b1; rx_index = IDX_W'(idx); rx_byte = b;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic first_sweep(input logic [9:0] own, input logic ten, input logic gc);
        cfg_own_addr = own; cfg_ten_bit = ten; cfg_gc_enable = gc;
        for (int i = 0; i < 256; i++) begin
            logic [7:0] b;
            logic is_gc, is_mk, is_pre, e_ack, e_sel;
            b      = 8'(i);
            is_gc  = (b == 8'h00);
            is_mk  = (b == 8'h01);
            is_pre = (b[7:3] == 5'b11110);
            e_sel  = !is_gc && !is_mk && !is_pre && !ten && (b[7:1] == own[6:0]);
            if (is_gc)       e_ack = gc;
            else if (is_mk)  e_ack = 1'b0;
            else if (is_pre) e_ack = ten && (b[2:1] == own[9:8]);
            else             e_ack = e_sel;
            pulse_start();
            send_byte(0, b);
            chk(is_pre ? (ten ? "R10" : "R9") : (is_gc ? "R3" : (is_mk ? "R8" : "R2")),
                "ack", int'(ack), int'(e_ack));
            chk("R2", "ack_valid", int'(ack_valid), 1);
            chk("R2", "addr_match", int'(addr_match), int'(e_sel));
            chk("R8", "start_byte_seen", int'(start_byte_seen), int'(is_mk));
            if (e_ack && !is_gc) chk("R2", "read_dir", int'(read_dir), int'(b[0]));
            pulse_stop();
            chk("R11", "match after stop", int'(addr_match), 0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk("R1", "ack_valid", int'(ack_valid), 0);
        chk("R1", "ack", int'(ack), 0);
        chk("R1", "addr_match", int'(addr_match), 0);
        chk("R1", "read_dir", int'(read_dir), 0);
        chk("R1", "requests", int'({gc_reset_req, gc_report_req, master_id_valid, start_byte_seen}), 0);
        chk("R1", "master_id", int'(master_id), 0);

        // R2 R3 R8 R9 R10: first-byte sweeps; upper own bits ignored in 7-bit mode
        first_sweep(10'h32A, 1'b0, 1'b1);
        first_sweep(10'h02A, 1'b0, 1'b0);
        first_sweep(10'h2A5, 1'b1, 1'b1);
        first_sweep(10'h17E, 1'b1, 1'b0);

        // R4 R5 R6 R7: broadcast command sweep
        cfg_own_addr = 10'h02A; cfg_ten_bit = 1'b0; cfg_gc_enable = 1'b1;
        for (int s = 0; s < 256; s++) begin
            logic [7:0] c;
            logic e_rst, e_rep, e_mv;
            c = 8'(s);
            e_rst = (c == 8'h06);
            e_rep = (c == 8'h06) || (c == 8'h04);
            e_mv  = c[0];
            pulse_start();
            send_byte(0, 8'h00);
            send_byte(1, c);
            chk("R6", "cmd ack_valid", int'(ack_valid), 1);
            chk(e_rep ? "R4" : (e_mv ? "R7" : "R6"), "cmd ack", int'(ack), int'(e_rep || e_mv));
            chk("R4", "gc_reset_req", int'(gc_reset_req), int'(e_rst));
            chk("R5", "gc_report_req", int'(gc_report_req), int'(e_rep));
            chk("R7", "master_id_valid", int'(master_id_valid), int'(e_mv));
            if (e_mv) chk("R7", "master_id", int'(master_id), int'(c[7:1]));
            pulse_stop();
        end

        // R3: disabled broadcast, command byte gives no decision
        cfg_gc_enable = 1'b0;
        pulse_start();
        send_byte(0, 8'h00);
        send_byte(1, 8'h06);
        chk("R3", "no decision", int'(ack_valid), 0);
        chk("R3", "no reset req", int'(gc_reset_req | gc_report_req), 0);
        pulse_stop();

        // R10: low-byte sweep after matching prefix 11110_10_0
        cfg_own_addr = 10'h2A5; cfg_ten_bit = 1'b1; cfg_gc_enable = 1'b1;
        for (int s = 0; s < 256; s++) begin
            pulse_start();
            send_byte(0, 8'hF4);
            chk("R10", "prefix ack", int'(ack), 1);
            chk("R10", "prefix no match yet", int'(addr_match), 0);
            send_byte(1, 8'(s));
            chk("R10", "low ack_valid", int'(ack_valid), 1);
            chk("R10", "low ack", int'(ack), int'(s == 'hA5));
            chk("R10", "low match", int'(addr_match), int'(s == 'hA5));
            pulse_stop();
        end
        // R10: read direction carried from prefix
        pulse_start();
        send_byte(0, 8'hF5);
        send_byte(1, 8'hA5);
        chk("R10", "read match", int'(addr_match), 1);
        chk("R10", "read_dir", int'(read_dir), 1);
        pulse_stop();
        // R10: mismatched prefix, low byte undecided
        pulse_start();
        send_byte(0, 8'hF2);
        chk("R10", "bad prefix ack", int'(ack), 0);
        send_byte(1, 8'hA5);
        chk("R10", "bad prefix low valid", int'(ack_valid), 0);
        chk("R10", "bad prefix match", int'(addr_match), 0);
        pulse_stop();

        // R11: stop between prefix and low byte
        pulse_start();
        send_byte(0, 8'hF4);
        pulse_stop();
        send_byte(1, 8'hA5);
        chk("R11", "low after stop", int'(ack_valid), 0);
        chk("R11", "match after stop", int'(addr_match), 0);

        // R11: repeated start clears selection
        cfg_own_addr = 10'h02A; cfg_ten_bit = 1'b0;
        pulse_start();
        send_byte(0, 8'h55);
        chk("R2", "selected", int'(addr_match), 1);
        chk("R2", "read_dir", int'(read_dir), 1);
        pulse_start();
        chk("R11", "cleared by restart", int'(addr_match), 0);
        chk("R11", "read_dir cleared", int'(read_dir), 0);

        // R11: byte coinciding with start is discarded
        @(negedge clk);
        bus_start = 1'b1; rx_valid = 1'b1; rx_index = '0; rx_byte = 8'h54;
        @(negedge clk);
        bus_start = 1'b0; rx_valid = 1'b0;
        chk("R11", "coincident byte valid", int'(ack_valid), 0);
        chk("R11", "coincident byte match", int'(addr_match), 0);

        // R12: later bytes silent, selection kept
        send_byte(0, 8'h54);
        send_byte(2, 8'h00);
        chk("R12", "idx2 no decision", int'(ack_valid), 0);
        chk("R12", "idx2 keeps match", int'(addr_match), 1);
        send_byte(5, 8'h55);
        chk("R12", "idx5 no decision", int'(ack_valid), 0);
        chk("R12", "idx5 keeps match", int'(addr_match), 1);
        pulse_stop();

        finished = 1'b1;
        report();
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            report();
        end
    end

endmodule